// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block collects a large set of level-sensitive interrupt lines and folds them into a smaller number of lines for a parent interrupt controller. The sources are organised in groups of eight. Each group has its own enable mask and drives one output line, which is high while any enabled source in the group is high. Source `n` of group `g` is input bit `g*8+n`.

Four neighbouring groups share one 32-bit register bank, and each group owns one byte lane of it. Group `g` lives in bank `g>>2`, in bits `8*(g%4)+7 : 8*(g%4)`. Bank `b` starts at byte offset `b*0x10`. Within a bank there are three registers:
- a write-one-to-set enable register, which also reads back the enable mask;
- a write-one-to-clear enable register;
- a status register that shows the enabled, active sources.

Software reaches the banks through a simple single-cycle read/write bus with registered read data. Every source passes through a two-flop synchronizer before it is masked. The group outputs are registered.

Top module: `irq_combiner`

## Requirements
- R1: While reset is asserted and after its release, every enable bit is 0, every `irq_out` bit is 0 and `bus_rdata` is 0.
- R2: A write to bank offset 0x0 sets each enable bit whose data bit is 1 and leaves the enable bits with data 0 unchanged. A read of offset 0x0 returns the bank's enable mask.
- R3: A write to bank offset 0x4 clears each enable bit whose data bit is 1 and leaves the others unchanged. Once all of group 0's bits are cleared, `irq_out[0]` is low from the second cycle after the write.
- R4: A read of bank offset 0xC returns one bit per source of the bank's four groups. The bit is 1 exactly when the synchronized source is high and its enable bit is set.
- R5: `irq_out[g]` is the registered OR of group g's eight status bits. A source change sampled at clock edge k reaches `irq_out` after edge k+2, so it is visible three cycles after it is driven. A change to the enable mask reaches `irq_out` one edge after the write.
- R6: Group g maps to bank g>>2 at byte offset (g>>2)*0x10, in bit lane 8*(g%4). Writes to one bank leave the other banks unchanged.
- R7: The following accesses read as 0, and writes to them change no enable bit in any bank:
  - offset 0x8;
  - reads of offset 0x4;
  - any address with a non-zero low two bits;
  - any bank at or above the implemented count.
- R8: `bus_rdata` carries the read value in the cycle after a read request (`bus_sel`=1, `bus_we`=0). It is 0 in every cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_GROUPS*8 | Level-sensitive interrupt sources, flat index g*8+n |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address: bank in bits [ADDR_W-1:4], register in [3:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, 0 when no read took place |
| irq_out | output | NUM_GROUPS | One registered line per group to the parent controller |

## Verification
The latency property assumes that the sources are the only cause of an asserted group line, and that the enable registers start from zero at reset. The register-clear property assumes that no new set write to bank 0 arrives in the single cycle that follows the clear. The random stimulus keeps to these assumptions in two ways:
- it issues writes through a task that always leaves an idle cycle between accesses;
- it changes the source levels only on the falling clock edge, and holds them for several cycles before any status is compared.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int LANE_W          = 8;
    localparam int GROUPS_PER_BANK = 4;
    localparam int BANK_W          = LANE_W * GROUPS_PER_BANK;

    typedef enum logic [1:0] {
        REG_EN_SET = 2'd0,
        REG_EN_CLR = 2'd1,
        REG_RSVD   = 2'd2,
        REG_STATUS = 2'd3
    } reg_sel_e;

    // Bits of a bank that belong to implemented groups.
    function automatic logic [BANK_W-1:0] lane_mask(input int lanes);
        logic [63:0] m;
        m = (64'd1 << (lanes * LANE_W)) - 64'd1;
        return m[BANK_W-1:0];
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign q_sync = stage2_q;

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter int LANES = GROUPS_PER_BANK
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       set_we,
    input  logic                       clr_we,
    input  logic [BANK_W-1:0]          wdata,
    input  logic [BANK_W-1:0]          src_sync,
    output logic [BANK_W-1:0]          en_q,
    output logic [BANK_W-1:0]          status,
    output logic [GROUPS_PER_BANK-1:0] grp_irq
);

    localparam logic [BANK_W-1:0] IMPL_MASK = lane_mask(LANES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (set_we) begin
            en_q <= en_q | (wdata & IMPL_MASK);
        end else if (clr_we) begin
            en_q <= en_q & ~wdata;
        end
    end

    assign status = src_sync & en_q;

    for (genvar l = 0; l < GROUPS_PER_BANK; l++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                grp_irq[l] <= 1'b0;
            end else begin
                grp_irq[l] <= |status[l*LANE_W +: LANE_W];
            end
        end
    end

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
    import irqc_pkg::*;
#(
    parameter int NUM_GROUPS = 20,
    parameter int ADDR_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_GROUPS*LANE_W-1:0] irq_src,
    input  logic                         bus_sel,
    input  logic                         bus_we,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [BANK_W-1:0]            bus_wdata,
    output logic [BANK_W-1:0]            bus_rdata,
    output logic [NUM_GROUPS-1:0]        irq_out
);

    localparam int NUM_SRC    = NUM_GROUPS * LANE_W;
    localparam int NUM_BANKS  = (NUM_GROUPS + GROUPS_PER_BANK - 1) / GROUPS_PER_BANK;
    localparam int PAD_W      = NUM_BANKS * BANK_W;
    localparam int BANK_IDX_W = ADDR_W - 4;

    logic [NUM_SRC-1:0]         src_sync;
    logic [PAD_W-1:0]           src_pad;
    logic [BANK_W-1:0]          en_arr   [NUM_BANKS];
    logic [BANK_W-1:0]          stat_arr [NUM_BANKS];
    logic [GROUPS_PER_BANK-1:0] grp_arr  [NUM_BANKS];

    logic [BANK_IDX_W-1:0] bank_idx;
    reg_sel_e              reg_sel;
    logic                  aligned;
    logic                  wr_req;
    logic                  rd_req;
    logic [BANK_W-1:0]     rd_next;

    irqc_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (irq_src),
        .q_sync  (src_sync)
    );

    assign src_pad  = PAD_W'(src_sync);
    assign bank_idx = bus_addr[ADDR_W-1:4];
    assign reg_sel  = reg_sel_e'(bus_addr[3:2]);
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign wr_req   = bus_sel && bus_we && aligned;
    assign rd_req   = bus_sel && !bus_we && aligned;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LEFT  = NUM_GROUPS - b * GROUPS_PER_BANK;
        localparam int LANES = (LEFT >= GROUPS_PER_BANK) ? GROUPS_PER_BANK : LEFT;

        logic hit;
        assign hit = (bank_idx == BANK_IDX_W'(b));

        irqc_bank #(.LANES(LANES)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_we   (wr_req && hit && (reg_sel == REG_EN_SET)),
            .clr_we   (wr_req && hit && (reg_sel == REG_EN_CLR)),
            .wdata    (bus_wdata),
            .src_sync (src_pad[b*BANK_W +: BANK_W]),
            .en_q     (en_arr[b]),
            .status   (stat_arr[b]),
            .grp_irq  (grp_arr[b])
        );
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_out
        assign irq_out[g] = grp_arr[g / GROUPS_PER_BANK][g % GROUPS_PER_BANK];
    end

    always_comb begin
        rd_next = '0;
        if (rd_req) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bank_idx == BANK_IDX_W'(b)) begin
                    unique case (reg_sel)
                        REG_EN_SET: rd_next = en_arr[b];
                        REG_STATUS: rd_next = stat_arr[b];
                        REG_EN_CLR,
                        REG_RSVD:   rd_next = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= rd_next;
        end
    end

endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk #(
    parameter int NUM_GROUPS = 20,
    parameter int ADDR_W     = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_GROUPS*8-1:0] irq_src,
    input logic                    bus_sel,
    input logic                    bus_we,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [31:0]             bus_wdata,
    input logic [31:0]             bus_rdata,
    input logic [NUM_GROUPS-1:0]   irq_out
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0));

    // R8
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_we) |=> (bus_rdata == '0));

    // R7
    rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr[3:2] == 2'b10) |=> (bus_rdata == '0));

    // R3
    clear_drops_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == ADDR_W'(4) && bus_wdata == '1)
        |-> ##2 !irq_out[0]);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_cause
        // R5
        src_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[g] |-> (|$past(irq_src[g*8 +: 8], 3)));
    end

endmodule

bind irq_combiner irq_combiner_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_src   (irq_src),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
);

// File: tb/test_irq_combiner.sv
module test_irq_combiner;

    localparam int CLK_PERIOD = 10;
    localparam int NG         = 20;
    localparam int NB         = 5;
    localparam int AW         = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NG*8-1:0] irq_src = '0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NG-1:0] irq_out;

    logic [31:0] en_m [NB];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_combiner #(.NUM_GROUPS(NG), .ADDR_W(AW)) i_irq_combiner (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] exp_stat(input int b);
        return irq_src[b*32 +: 32] & en_m[b];
    endfunction

    function automatic logic [NG-1:0] exp_out();
        logic [NG-1:0] r;
        for (int g = 0; g < NG; g++) begin
            logic [31:0] s;
            s = exp_stat(g / 4);
            r[g] = |s[(g % 4)*8 +: 8];
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        for (int b = 0; b < NB; b++) en_m[b] = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 out in reset", 32'(irq_out), 32'h0);
        chk("R1 rdata in reset", bus_rdata, 32'h0);
        rst_n = 1;
        irq_src = '1;
        repeat (4) @(negedge clk);
        chk("R1 out after reset", 32'(irq_out), 32'h0);
        for (int b = 0; b < NB; b++) begin
            rd(AW'(b*16), d);
            chk("R1 enable after reset", d, 32'h0);
        end
        // R8: idle cycle after a read
        @(negedge clk);
        chk("R8 idle rdata", bus_rdata, 32'h0);
        irq_src = '0;

        // R5: latency from source to output
        wr(8'h00, 32'h1);
        en_m[0] = 32'h1;
        repeat (3) @(negedge clk);
        irq_src[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R5 out after two edges", 32'(irq_out[0]), 32'h0);
        @(negedge clk);
        chk("R5 out after three edges", 32'(irq_out[0]), 32'h1);

        // R3: clearing the enable drops the output one edge after the write
        wr(8'h04, 32'h1);
        en_m[0] = 32'h0;
        chk("R3 out before update", 32'(irq_out[0]), 32'h1);
        @(negedge clk);
        chk("R3 out after clear", 32'(irq_out[0]), 32'h0);
        irq_src[0] = 1'b0;

        // R6: a set in bank 2 lane 1 (group 9, source 3 -> flat 75)
        wr(8'h20, 32'h0000_0800);
        en_m[2] = 32'h0000_0800;
        irq_src[75] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R6 group 9 out", 32'(irq_out), 32'(20'h00200));
        rd(8'h2C, d);
        chk("R6 bank 2 status", d, 32'h0000_0800);
        rd(8'h1C, d);
        chk("R6 bank 1 status", d, 32'h0);

        // R7: reserved offsets, clear-register reads, unaligned, out of range
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h50, 32'hFFFF_FFFF);
        wr(8'h61, 32'hFFFF_FFFF);
        wr(8'h21, 32'hFFFF_FFFF);
        for (int b = 0; b < NB; b++) begin
            rd(AW'(b*16), d);
            chk("R7 enables untouched", d, en_m[b]);
        end
        rd(8'h08, d); chk("R7 read 0x8", d, 32'h0);
        rd(8'h24, d); chk("R7 read clear reg", d, 32'h0);
        rd(8'h50, d); chk("R7 read bank 5", d, 32'h0);
        rd(8'h2E, d); chk("R7 unaligned status", d, 32'h0);
        chk("R7 out unchanged", 32'(irq_out), 32'(exp_out()));

        // R2 R3 R4 R5: random set/clear and source patterns
        for (int it = 0; it < 60; it++) begin
            int b;
            logic [31:0] w;
            b = $urandom_range(0, NB-1);
            w = $urandom;
            if ($urandom_range(0, 2) != 0) begin
                wr(AW'(b*16), w);
                en_m[b] = en_m[b] | w;
            end else begin
                wr(AW'(b*16 + 4), w);
                en_m[b] = en_m[b] & ~w;
            end
            for (int k = 0; k < NB; k++) irq_src[k*32 +: 32] = $urandom & $urandom;
            repeat (4) @(negedge clk);
            chk("R5 group outputs", 32'(irq_out), 32'(exp_out()));
            for (int k = 0; k < NB; k++) begin
                rd(AW'(k*16), d);
                chk("R2 enable readback", d, en_m[k]);
                rd(AW'(k*16 + 12), d);
                chk("R4 status", d, exp_stat(k));
            end
        end

        // R2 R3: full set then full clear
        for (int b = 0; b < NB; b++) begin
            wr(AW'(b*16), 32'hFFFF_FFFF);
            en_m[b] = 32'hFFFF_FFFF;
        end
        irq_src = '1;
        repeat (4) @(negedge clk);
        chk("R2 all outputs", 32'(irq_out), 32'(20'hFFFFF));
        for (int b = 0; b < NB; b++) begin
            wr(AW'(b*16 + 4), 32'hFFFF_FFFF);
            en_m[b] = 32'h0;
        end
        repeat (2) @(negedge clk);
        chk("R3 all cleared", 32'(irq_out), 32'h0);

        finish_run();
    end

endmodule